// File: doc/BRIEF.md
# Source-Side Descriptor-Chain DMA Reader

This block fetches input bytes from memory and hands them, one 32-bit word at a time, to a downstream hash engine over a valid/ready stream. It runs in one of two ways, chosen when a transfer starts. In single-buffer mode it reads one buffer described by a start address and a byte count. In chain mode it reads a 16-byte descriptor from memory, streams the buffer that descriptor names, and then follows the descriptor's link to the next one. It stops at the first descriptor whose terminate flag is set.

A descriptor occupies four consecutive words at increasing addresses. The first word is the buffer address, the second is the buffer length in bytes, the third is the link to the next descriptor, and the fourth holds the flags. Bit 31 of the flags word is the terminate flag. The control word carries three fields. Bit 31 enables the block and is watched for the whole transfer. Bit 25 selects chain mode. Bits 30:28 are a three-bit memory attribute that is copied onto every read request. The block keeps at most one memory read in flight.

A done pulse fires once the last byte has been accepted by the consumer, whatever the consumer does with it afterwards. A read error pulses a separate error output instead. Buffer addresses are word aligned. Bytes are packed little-endian: the byte at the lowest address sits in bits 7:0.

Top module: `src_chain_dma`

## Requirements
- R1: In single-buffer mode (control bit 25 clear), a start pulse reads `src_size` bytes from word addresses `src_addr`, `src_addr+4`, and so on, and emits them in that order. Only the final beat has `out_last` set, and `evt_src_done` pulses once with no descriptor read.
- R2: In chain mode (control bit 25 set), the block first reads the descriptor at `desc_ptr`, at addresses +0, +4, +8 and +12 in that order. It then streams that descriptor's buffer and fetches the next descriptor from the link word, at offset +8.
- R3: A descriptor whose flags word (offset +12) has bit 31 set is the last one. Its link is never fetched, and `out_last` is set only on the final beat of that last buffer.
- R4: A descriptor with length zero, or a single-buffer transfer of size zero, issues no data reads. The zero-length descriptor is skipped and its link is followed; the zero-size transfer pulses `evt_src_done` directly.
- R5: `out_bvalid` is 4'b1111 for a full word. On the final beat of a buffer of length L where L mod 4 is nonzero, it is 4'b0001, 4'b0011 or 4'b0111 for a remainder of 1, 2 or 3.
- R6: Every memory request carries, on `mem_req_attr`, control bits 30:28 as captured at start.
- R7: At most one memory read is outstanding at a time. `evt_src_done` pulses in the cycle after the final beat is accepted and never together with `evt_rd_err`.
- R8: A read response with `mem_rsp_err` set stops the transfer. It pulses `evt_rd_err`, returns the block to idle, and no further beat or `evt_src_done` follows.
- R9: Clearing control bit 31 during a transfer ends it after the beat currently offered is accepted. The block goes idle and does not pulse `evt_src_done`.
- R10: A start pulse is ignored while the block is busy or while control bit 31 is clear.
- R11: An offered output beat keeps `out_valid`, `out_data` and `out_bvalid` stable until `out_ready` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_word | input | 32 | Control: bit 31 enable, bit 25 chain mode, bits 30:28 memory attribute |
| src_addr | input | AW | Single-buffer start address |
| src_size | input | LW | Single-buffer byte count |
| desc_ptr | input | AW | Address of the first descriptor in chain mode |
| start | input | 1 | Start pulse |
| busy | output | 1 | Transfer in progress |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | AW | Word address of the read |
| mem_req_attr | output | 3 | Attribute copied from control bits 30:28 |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| mem_rsp_err | input | 1 | Read failed |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer accepts beat |
| out_data | output | 32 | Output word, lowest address in bits 7:0 |
| out_bvalid | output | 4 | Valid bytes of the beat |
| out_last | output | 1 | Final beat of the transfer |
| evt_src_done | output | 1 | Pulse: all input handed to consumer |
| evt_rd_err | output | 1 | Pulse: read error ended the transfer |

## Verification
The bound checker watches these rules on every cycle:
- only one read in flight;
- an offered beat held stable under backpressure;
- byte masks restricted to the four legal contiguous patterns;
- done and error never together, and an error always landing in idle;
- the final beat always followed by done;
- no requests or beats while idle.

Only the directed scenarios can show the rest:
- the order of descriptor and data addresses;
- that a terminate flag suppresses the link fetch;
- that zero-length descriptors generate no reads;
- the attribute value;
- that an abort or an error stops the stream at the right beat.

// File: rtl/src_chain_dma.sv
module src_chain_dma #(
  parameter int AW = 32,
  parameter int LW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [31:0]   ctl_word,
  input  logic [AW-1:0] src_addr,
  input  logic [LW-1:0] src_size,
  input  logic [AW-1:0] desc_ptr,
  input  logic          start,
  output logic          busy,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic [AW-1:0] mem_req_addr,
  output logic [2:0]    mem_req_attr,
  input  logic          mem_rsp_valid,
  input  logic [31:0]   mem_rsp_data,
  input  logic          mem_rsp_err,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [31:0]   out_data,
  output logic [3:0]    out_bvalid,
  output logic          out_last,
  output logic          evt_src_done,
  output logic          evt_rd_err
);
  typedef enum logic [2:0] {S_IDLE, S_DREQ, S_DWAIT, S_RREQ, S_RWAIT, S_OUT} st_t;

  st_t           st;
  logic [AW-1:0] dptr, cur, nxt;
  logic [LW-1:0] remain;
  logic [1:0]    widx;
  logic          chain, final_desc;
  logic [2:0]    attr;
  logic [31:0]   word_q;
  logic          done_q, err_q;

  wire en      = ctl_word[31];
  wire seg_end = remain <= LW'(4);

  assign busy          = st != S_IDLE;
  assign mem_req_valid = (st == S_DREQ || st == S_RREQ) && en;
  assign mem_req_addr  = (st == S_DREQ) ? dptr + AW'({widx, 2'b00}) : cur;
  assign mem_req_attr  = attr;
  assign out_valid     = st == S_OUT;
  assign out_data      = word_q;
  assign out_last      = out_valid && seg_end && (!chain || final_desc);
  assign out_bvalid    = seg_end ? (4'b1111 >> (3'd4 - 3'(remain))) : 4'b1111;
  assign evt_src_done  = done_q;
  assign evt_rd_err    = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      dptr <= '0;
      cur <= '0;
      nxt <= '0;
      remain <= '0;
      widx <= '0;
      chain <= 1'b0;
      final_desc <= 1'b0;
      attr <= '0;
      word_q <= '0;
      done_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: if (start && en) begin
          attr  <= ctl_word[30:28];
          chain <= ctl_word[25];
          if (ctl_word[25]) begin
            dptr <= desc_ptr;
            widx <= '0;
            st   <= S_DREQ;
          end else begin
            cur        <= src_addr;
            remain     <= src_size;
            final_desc <= 1'b1;
            if (src_size == '0) done_q <= 1'b1;
            else                st <= S_RREQ;
          end
        end
        S_DREQ: begin
          if (!en)                st <= S_IDLE;
          else if (mem_req_ready) st <= S_DWAIT;
        end
        S_DWAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            err_q <= 1'b1;
            st    <= S_IDLE;
          end else if (!en) begin
            st <= S_IDLE;
          end else begin
            widx <= widx + 2'd1;
            case (widx)
              2'd0: begin cur <= AW'(mem_rsp_data); st <= S_DREQ; end
              2'd1: begin remain <= LW'(mem_rsp_data); st <= S_DREQ; end
              2'd2: begin nxt <= AW'(mem_rsp_data); st <= S_DREQ; end
              default: begin
                final_desc <= mem_rsp_data[31];
                if (remain != '0) st <= S_RREQ;
                else if (mem_rsp_data[31]) begin
                  done_q <= 1'b1;
                  st     <= S_IDLE;
                end else begin
                  dptr <= nxt;
                  st   <= S_DREQ;
                end
              end
            endcase
          end
        end
        S_RREQ: begin
          if (!en)                st <= S_IDLE;
          else if (mem_req_ready) st <= S_RWAIT;
        end
        S_RWAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            err_q <= 1'b1;
            st    <= S_IDLE;
          end else if (!en) begin
            st <= S_IDLE;
          end else begin
            word_q <= mem_rsp_data;
            st     <= S_OUT;
          end
        end
        S_OUT: if (out_ready) begin
          if (seg_end) begin
            if (!chain || final_desc) begin
              done_q <= 1'b1;
              st     <= S_IDLE;
            end else if (!en) begin
              st <= S_IDLE;
            end else begin
              dptr <= nxt;
              widx <= '0;
              st   <= S_DREQ;
            end
          end else begin
            remain <= remain - LW'(4);
            cur    <= cur + AW'(4);
            st     <= en ? S_RREQ : S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/src_chain_dma_chk.sv
module src_chain_dma_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       mem_req_valid,
  input logic       mem_req_ready,
  input logic       mem_rsp_valid,
  input logic       out_valid,
  input logic       out_ready,
  input logic [31:0] out_data,
  input logic [3:0] out_bvalid,
  input logic       out_last,
  input logic       evt_src_done,
  input logic       evt_rd_err
);
  logic pend;
  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else if (mem_req_valid && mem_req_ready) pend <= 1'b1;
    else if (mem_rsp_valid) pend <= 1'b0;
  end

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !pend); // R7
  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_bvalid)); // R11
  AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_bvalid == 4'b0001 || out_bvalid == 4'b0011 ||
                   out_bvalid == 4'b0111 || out_bvalid == 4'b1111)); // R5
  AST_DONE_ERR_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_src_done && evt_rd_err)); // R7
  AST_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_rd_err |-> !busy && !evt_src_done); // R8
  AST_LAST_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> evt_src_done); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req_valid && !out_valid); // R10
endmodule

bind src_chain_dma src_chain_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_rsp_valid(mem_rsp_valid), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data), .out_bvalid(out_bvalid), .out_last(out_last),
  .evt_src_done(evt_src_done), .evt_rd_err(evt_rd_err)
);

// File: tb/sim_src_chain_dma.sv
`timescale 1ns/1ps
module sim_src_chain_dma;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [31:0] ctl_word = '0, src_addr = '0, src_size = '0, desc_ptr = '0;
  logic start = 1'b0;
  logic busy, mem_req_valid, mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr;
  logic [2:0] mem_req_attr;
  logic mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
  logic [31:0] mem_rsp_data = '0;
  logic out_valid, out_ready = 1'b1, out_last;
  logic [31:0] out_data;
  logic [3:0] out_bvalid;
  logic evt_src_done, evt_rd_err;

  src_chain_dma u0 (.*);

  logic [31:0] mem [1024];
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  logic pend = 1'b0;
  int cnt = 0;
  logic [31:0] paddr = '0;
  int rd_n = 0, overlap = 0;
  logic [31:0] rd_log [1024];
  logic [2:0] last_attr = '0;
  int rx_n = 0, done_n = 0, err_n = 0;
  logic [31:0] rx_d [1024];
  logic [3:0] rx_b [1024];
  logic rx_l [1024];
  logic hold = 1'b0, bp = 1'b0;
  logic [7:0] lfsr = 8'h5B;
  int total = 0, bad = 0;

  function automatic logic [31:0] fill(int i);
    logic [7:0] b = 8'(i);
    return {b ^ 8'h5A, b, 8'hC3, ~b};
  endfunction

  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[paddr[11:2]];
        mem_rsp_err   <= (paddr == err_addr);
        pend <= 1'b0;
      end else cnt <= cnt - 1;
    end
    if (mem_req_valid && mem_req_ready) begin
      if (pend) overlap <= overlap + 1;
      pend <= 1'b1;
      cnt <= 2;
      paddr <= mem_req_addr;
      rd_log[rd_n % 1024] <= mem_req_addr;
      last_attr <= mem_req_attr;
      rd_n <= rd_n + 1;
    end
    if (out_valid && out_ready) begin
      rx_d[rx_n % 1024] <= out_data;
      rx_b[rx_n % 1024] <= out_bvalid;
      rx_l[rx_n % 1024] <= out_last;
      rx_n <= rx_n + 1;
    end
    if (evt_src_done) done_n <= done_n + 1;
    if (evt_rd_err) err_n <= err_n + 1;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= hold ? 1'b0 : (bp ? lfsr[0] : 1'b1);
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic kick(logic [31:0] ctl, logic [31:0] sa, logic [31:0] sz, logic [31:0] dp);
    @(negedge clk);
    ctl_word = ctl; src_addr = sa; src_size = sz; desc_ptr = dp; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    @(negedge clk);
    while (busy && n < 5000) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    check("R10 reset busy", 32'(busy), 0);
    check("R10 reset out_valid", 32'(out_valid), 0);
    check("R10 reset req_valid", 32'(mem_req_valid), 0);
  endtask

  task automatic t_direct_full();
    int r0 = rd_n, x0 = rx_n, d0 = done_n;
    kick(32'h8000_0000, 32'h40, 16, 0);
    wait_idle();
    check("R1 beats", 32'(rx_n - x0), 4);
    for (int i = 0; i < 4; i++) begin
      check("R1 data", rx_d[x0 + i], fill(16 + i));
      check("R1 read addr", rd_log[r0 + i], 32'h40 + 32'(4 * i));
      check("R5 full mask", 32'(rx_b[x0 + i]), 4'hF);
      check("R1 last flag", 32'(rx_l[x0 + i]), (i == 3) ? 1 : 0);
    end
    check("R1 done", 32'(done_n - d0), 1);
  endtask

  task automatic t_direct_partial();
    int x0 = rx_n;
    kick(32'h8000_0000, 32'h40, 7, 0);
    wait_idle();
    check("R5 beats", 32'(rx_n - x0), 2);
    check("R5 mask first", 32'(rx_b[x0]), 4'hF);
    check("R5 mask tail 3", 32'(rx_b[x0 + 1]), 4'h7);
    check("R5 tail data", rx_d[x0 + 1], fill(17));
  endtask

  task automatic t_direct_zero();
    int r0 = rd_n, d0 = done_n;
    kick(32'h8000_0000, 32'h40, 0, 0);
    wait_idle();
    check("R4 zero size reads", 32'(rd_n - r0), 0);
    check("R4 zero size done", 32'(done_n - d0), 1);
  endtask

  task automatic t_chain();
    int r0 = rd_n, x0 = rx_n, d0 = done_n;
    mem[64] = 32'h200; mem[65] = 8;  mem[66] = 32'h120; mem[67] = 32'h0;
    mem[72] = 32'h240; mem[73] = 0;  mem[74] = 32'h140; mem[75] = 32'h0;
    mem[80] = 32'h280; mem[81] = 5;  mem[82] = 32'h3F0; mem[83] = 32'h8000_0000;
    bp = 1'b1;
    kick(32'hD200_0000, 0, 0, 32'h100);
    wait_idle();
    bp = 1'b0;
    check("R2 desc addr0", rd_log[r0], 32'h100);
    check("R2 desc addr1", rd_log[r0 + 1], 32'h104);
    check("R2 desc addr2", rd_log[r0 + 2], 32'h108);
    check("R2 desc addr3", rd_log[r0 + 3], 32'h10C);
    check("R2 data addr", rd_log[r0 + 4], 32'h200);
    check("R2 link followed", rd_log[r0 + 6], 32'h120);
    check("R4 zero desc skipped", rd_log[r0 + 10], 32'h140);
    check("R3 total reads", 32'(rd_n - r0), 16);
    check("R11 beats under backpressure", 32'(rx_n - x0), 4);
    check("R2 data0", rx_d[x0], fill(128));
    check("R2 data1", rx_d[x0 + 1], fill(129));
    check("R11 data2", rx_d[x0 + 2], fill(160));
    check("R11 data3", rx_d[x0 + 3], fill(161));
    check("R5 mask tail 1", 32'(rx_b[x0 + 3]), 4'h1);
    check("R3 last only at end", {29'd0, rx_l[x0 + 1], rx_l[x0 + 2], rx_l[x0 + 3]}, 1);
    check("R6 attribute", 32'(last_attr), 5);
    check("R3 done", 32'(done_n - d0), 1);
  endtask

  task automatic t_error();
    int x0 = rx_n, d0 = done_n, e0 = err_n;
    err_addr = 32'h48;
    kick(32'h8000_0000, 32'h40, 16, 0);
    wait_idle();
    err_addr = 32'hFFFF_FFFF;
    check("R8 beats before error", 32'(rx_n - x0), 2);
    check("R8 error pulse", 32'(err_n - e0), 1);
    check("R8 no done", 32'(done_n - d0), 0);
    check("R8 idle", 32'(busy), 0);
  endtask

  task automatic t_abort();
    int x0 = rx_n, d0 = done_n, n = 0;
    hold = 1'b1;
    kick(32'h8000_0000, 32'h40, 64, 0);
    while (!out_valid && n < 100) begin @(negedge clk); n++; end
    ctl_word = 32'h0;
    hold = 1'b0;
    wait_idle();
    check("R9 beats after abort", 32'(rx_n - x0), 1);
    check("R9 no done", 32'(done_n - d0), 0);
    check("R9 idle", 32'(busy), 0);
  endtask

  task automatic t_ignored_start();
    int r0 = rd_n, x0 = rx_n, d0 = done_n;
    kick(32'h0000_0000, 32'h40, 16, 0);
    repeat (3) @(negedge clk);
    check("R10 disabled start busy", 32'(busy), 0);
    check("R10 disabled start reads", 32'(rd_n - r0), 0);
    kick(32'h8000_0000, 32'h40, 16, 0);
    repeat (2) @(negedge clk);
    src_size = 4; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_idle();
    check("R10 restart ignored beats", 32'(rx_n - x0), 4);
    check("R10 single done", 32'(done_n - d0), 1);
    check("R7 one read in flight", 32'(overlap), 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = fill(i);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct_full();
    t_direct_partial();
    t_direct_zero();
    t_chain();
    t_error();
    t_abort();
    t_ignored_start();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule